// File: doc/BRIEF.md
# Microcoded Control Sequencer with Encoded Microword Fields

This block steers a multi-cycle processor datapath from a small microcode store. A micro-address register selects one microword per clock. A local decoder turns the microword's compact, encoded fields into individual control lines: ALU function and operand selects, memory strobes and address source, instruction-register load, register-file write with its data source and destination, branch-target capture, and program-counter update controls.

The microword's sequencing field selects the next micro-address. It can return to the fetch step, jump through an opcode-indexed dispatch table, or advance to the next word. Actions that never happen together share one encoded field, so the decoder cannot produce an illegal combination of those lines. The datapath, including the ALU zero flag that qualifies a conditional PC write, is outside the block. Only the opcode comes in.

Top module: `mcode_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the micro-address becomes 0. Word 0 is the fetch step, which drives `mem_rd`=1, `mem_addr_alu`=0, `ir_wr`=1, `src_a_sel`=0, `src_b_sel`=001, `alu_op`=00, `pc_wr`=1 and `pc_src`=00.
- R2: A sequencing code of 10 makes the next micro-address the current one plus one. Steps 0→1, 2→3, 3→4, 5→6, 7→8 and 9→10 use it.
- R3: A sequencing code of 00 (and the unused code 11) returns the micro-address to 0. Steps 4, 6, 8, 10, 11 and 12 end this way.
- R4: A sequencing code of 01 (used by step 1) loads the dispatch entry for `opcode`: 000000→7, 100011→2, 101011→5, 001101→9, 000100→11, 000010→12.
- R5: Any opcode not listed in R4 dispatches to micro-address 0.
- R6: `alu_op` encodes 00 add, 01 subtract, 10 function-field operation, 11 OR. Step 7 drives 10, step 9 drives 11 and step 11 drives 01.
- R7: `src_b_sel` encodes 000 rt, 001 constant 4, 010 sign-extended immediate, 011 sign-extended immediate shifted left by 2, 100 zero-extended immediate. `src_a_sel` is 0 for PC and 1 for rs. Step 1 uses PC with 011, steps 2 and 5 use rs with 010, and step 9 uses rs with 100.
- R8: `pc_src` encodes 00 ALU, 01 target register, 10 jump address. Step 11 drives `pc_wr_cond`=1, `pc_wr`=0, `pc_src`=01. Step 12 drives `pc_wr`=1, `pc_wr_cond`=0, `pc_src`=10.
- R9: `mem_rd` and `mem_wr` come from one encoded field and are never both 1. `mem_addr_alu` is 1 for PC-independent accesses: the data read in step 3 and the write in step 6.
- R10: Register writes come from one encoded field. Step 4 gives `reg_wr`=1, `reg_from_mem`=1, `reg_dst_rd`=0. Step 8 gives `reg_wr`=1, `reg_from_mem`=0, `reg_dst_rd`=1. Step 10 gives `reg_wr`=1, `reg_from_mem`=0, `reg_dst_rd`=0. `target_wr` is 1 only in step 1.
- R11: Reset takes priority over sequencing. A low `rst_n` at the edge leaving step 1 gives micro-address 0, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the current instruction |
| uaddr | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU function |
| src_a_sel | output | 1 | First ALU operand: 0 PC, 1 rs |
| src_b_sel | output | 3 | Second ALU operand select |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr_alu | output | 1 | Memory address: 0 PC, 1 ALU result |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_from_mem | output | 1 | Register write data: 0 ALU, 1 memory |
| reg_dst_rd | output | 1 | Register destination: 0 rt, 1 rd |
| target_wr | output | 1 | Branch-target register load |
| pc_wr | output | 1 | Unconditional PC update |
| pc_wr_cond | output | 1 | PC update qualified by ALU zero |
| pc_src | output | 2 | PC next-value source |

## Verification
Reset and the dispatch jump can land in the same cycle. The bench pulls `rst_n` low at the falling edge while the sequencer sits in step 1 with a valid opcode applied. It then judges the following cycle: the micro-address must be 0 and the fetch controls must be present, not the dispatch target. Every cycle, a behavioural step model predicts the micro-address and the full set of decoded controls. The bench compares both against the outputs, including dispatches on undefined opcodes.

// File: rtl/mc_pkg.sv
// Package: shared encodings and microword layout for the microcoded controller.
// Assumes a 4-bit micro-address space and a 6-bit opcode.
package mc_pkg;
    localparam int UPC_W = 4;
    localparam int OPC_W = 6;

    typedef enum logic [1:0] {SEQ_ZERO = 2'b00, SEQ_DISP = 2'b01, SEQ_NEXT = 2'b10, SEQ_RSVD = 2'b11} seq_e;
    typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNC = 2'b10, ALU_OR = 2'b11} alu_e;
    typedef enum logic [2:0] {SB_RT = 3'd0, SB_FOUR = 3'd1, SB_SEXT = 3'd2, SB_SEXT_SH = 3'd3, SB_ZEXT = 3'd4} srcb_e;
    typedef enum logic [1:0] {RW_NONE = 2'b00, RW_ALU_RD = 2'b01, RW_ALU_RT = 2'b10, RW_MEM_RT = 2'b11} regw_e;
    typedef enum logic [1:0] {MO_NONE = 2'b00, MO_READ = 2'b01, MO_WRITE = 2'b10, MO_IDLE = 2'b11} memop_e;
    typedef enum logic [1:0] {PS_ALU = 2'b00, PS_TGT = 2'b01, PS_JUMP = 2'b10, PS_RSVD = 2'b11} pcsrc_e;

    // Microword, most significant field first; sequencing sits in the low bits.
    typedef struct packed {
        pcsrc_e pcsrc;
        logic   pccond;
        logic   pcwr;
        logic   iord;
        memop_e memop;
        logic   ir;
        logic   tgt;
        regw_e  regw;
        srcb_e  srcb;
        logic   srca;
        alu_e   alu;
        seq_e   seq;
    } uword_t;

    localparam int UW_W = $bits(uword_t);

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OP_ORIMM = 6'b001101;
    localparam logic [OPC_W-1:0] OP_BREQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OP_JUMP  = 6'b000010;
endpackage

// File: rtl/mc_rom.sv
// Module: microcode store, combinational read.
// Assumes addresses beyond the last programmed step hold an all-zero word (return to fetch).
module mc_rom
    import mc_pkg::*;
#(
    parameter int AW = UPC_W
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);
    // Look up the microword for the current step.
    always_comb begin
        word = '0;
        case (addr)
            4'd0: begin
                word.memop = MO_READ; word.ir = 1'b1; word.srcb = SB_FOUR;
                word.pcwr = 1'b1; word.pcsrc = PS_ALU; word.seq = SEQ_NEXT;
            end
            4'd1: begin
                word.srcb = SB_SEXT_SH; word.tgt = 1'b1; word.seq = SEQ_DISP;
            end
            4'd2: begin
                word.srca = 1'b1; word.srcb = SB_SEXT; word.seq = SEQ_NEXT;
            end
            4'd3: begin
                word.memop = MO_READ; word.iord = 1'b1; word.seq = SEQ_NEXT;
            end
            4'd4: begin
                word.regw = RW_MEM_RT; word.seq = SEQ_ZERO;
            end
            4'd5: begin
                word.srca = 1'b1; word.srcb = SB_SEXT; word.seq = SEQ_NEXT;
            end
            4'd6: begin
                word.memop = MO_WRITE; word.iord = 1'b1; word.seq = SEQ_ZERO;
            end
            4'd7: begin
                word.srca = 1'b1; word.srcb = SB_RT; word.alu = ALU_FUNC; word.seq = SEQ_NEXT;
            end
            4'd8: begin
                word.regw = RW_ALU_RD; word.seq = SEQ_ZERO;
            end
            4'd9: begin
                word.srca = 1'b1; word.srcb = SB_ZEXT; word.alu = ALU_OR; word.seq = SEQ_NEXT;
            end
            4'd10: begin
                word.regw = RW_ALU_RT; word.seq = SEQ_ZERO;
            end
            4'd11: begin
                word.srca = 1'b1; word.srcb = SB_RT; word.alu = ALU_SUB;
                word.pccond = 1'b1; word.pcsrc = PS_TGT; word.seq = SEQ_ZERO;
            end
            4'd12: begin
                word.pcwr = 1'b1; word.pcsrc = PS_JUMP; word.seq = SEQ_ZERO;
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/mc_dispatch.sv
// Module: opcode dispatch table giving the first micro-address of each instruction.
// Assumes unknown opcodes must fall back to the fetch step (address 0).
module mc_dispatch
    import mc_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int AW = UPC_W
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] target
);
    // Map each known opcode to its entry step.
    always_comb begin
        case (opcode)
            OP_RTYPE: target = AW'(7);
            OP_LOAD:  target = AW'(2);
            OP_STORE: target = AW'(5);
            OP_ORIMM: target = AW'(9);
            OP_BREQ:  target = AW'(11);
            OP_JUMP:  target = AW'(12);
            default:  target = '0;
        endcase
    end
endmodule

// File: rtl/mc_seq.sv
// Module: micro-address register and next-address select.
// Assumes a synchronous active-low reset that overrides every sequencing code.
module mc_seq
    import mc_pkg::*;
#(
    parameter int AW = UPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_e          seq,
    input  logic [AW-1:0] disp_addr,
    output logic [AW-1:0] upc
);
    logic [AW-1:0] upc_nxt;

    // Choose the next micro-address from the sequencing code.
    always_comb begin
        case (seq)
            SEQ_DISP: upc_nxt = disp_addr;
            SEQ_NEXT: upc_nxt = upc + AW'(1);
            default:  upc_nxt = '0;
        endcase
    end

    // Hold the micro-address; reset returns it to the fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= '0;
        else        upc <= upc_nxt;
    end
endmodule

// File: rtl/mc_decode.sv
// Module: expands the encoded microword fields into one line per control point.
// Assumes memory-source register writes target rt and ALU-source writes name rd or rt.
module mc_decode
    import mc_pkg::*;
(
    input  uword_t      word,
    output logic [1:0]  alu_op,
    output logic        src_a_sel,
    output logic [2:0]  src_b_sel,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        mem_addr_alu,
    output logic        ir_wr,
    output logic        reg_wr,
    output logic        reg_from_mem,
    output logic        reg_dst_rd,
    output logic        target_wr,
    output logic        pc_wr,
    output logic        pc_wr_cond,
    output logic [1:0]  pc_src,
    output logic [1:0]  seq_code
);
    // Decode each field into its control lines.
    always_comb begin
        alu_op       = word.alu;
        src_a_sel    = word.srca;
        src_b_sel    = word.srcb;
        mem_rd       = (word.memop == MO_READ);
        mem_wr       = (word.memop == MO_WRITE);
        mem_addr_alu = word.iord;
        ir_wr        = word.ir;
        reg_wr       = (word.regw != RW_NONE);
        reg_from_mem = (word.regw == RW_MEM_RT);
        reg_dst_rd   = (word.regw == RW_ALU_RD);
        target_wr    = word.tgt;
        pc_wr        = word.pcwr;
        pc_wr_cond   = word.pccond;
        pc_src       = word.pcsrc;
        seq_code     = word.seq;
    end
endmodule

// File: rtl/mcode_ctrl.sv
// Module: top of the microcoded controller: sequencer, store, dispatch and field decoder.
// Assumes the datapath gates pc_wr_cond with its ALU zero flag.
module mcode_ctrl
    import mc_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int AW = UPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] uaddr,
    output logic [1:0]    alu_op,
    output logic          src_a_sel,
    output logic [2:0]    src_b_sel,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_addr_alu,
    output logic          ir_wr,
    output logic          reg_wr,
    output logic          reg_from_mem,
    output logic          reg_dst_rd,
    output logic          target_wr,
    output logic          pc_wr,
    output logic          pc_wr_cond,
    output logic [1:0]    pc_src
);
    uword_t        word;
    logic [AW-1:0] disp_addr;
    logic [1:0]    seq_code;

    mc_rom #(.AW(AW)) u_rom (.addr(uaddr), .word(word));

    mc_dispatch #(.OW(OW), .AW(AW)) u_disp (.opcode(opcode), .target(disp_addr));

    mc_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .seq(word.seq), .disp_addr(disp_addr), .upc(uaddr)
    );

    mc_decode u_dec (
        .word(word), .alu_op(alu_op), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu), .ir_wr(ir_wr),
        .reg_wr(reg_wr), .reg_from_mem(reg_from_mem), .reg_dst_rd(reg_dst_rd),
        .target_wr(target_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
        .seq_code(seq_code)
    );
endmodule

// File: rtl/mc_ctrl_chk.sv
// Module: property checker for mcode_ctrl, attached by bind.
// Assumes the decoded sequencing code is visible inside the top as seq_code.
module mc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] uaddr,
    input logic [1:0] seq_code,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mem_addr_alu,
    input logic       reg_wr,
    input logic       reg_from_mem,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic [1:0] pc_src
);
    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (uaddr == 4'd0));
    p_step_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_code == 2'b10) |=> (uaddr == $past(uaddr) + 4'd1));
    p_step_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_code == 2'b00) |=> (uaddr == 4'd0));
    p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
    p_wr_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr_alu);
    p_regsrc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_from_mem |-> reg_wr);
    p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == 2'b10) |-> (pc_wr && !pc_wr_cond));
    p_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |-> (pc_src == 2'b01 && !pc_wr));
endmodule

bind mcode_ctrl mc_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .uaddr(uaddr), .seq_code(seq_code),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu),
    .reg_wr(reg_wr), .reg_from_mem(reg_from_mem),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src)
);

// File: tb/mcode_ctrl_test.sv
// Bench: behavioural step model of the controller, compared every cycle.
module mcode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic [3:0] uaddr;
    logic [1:0] alu_op, pc_src;
    logic [2:0] src_b_sel;
    logic src_a_sel, mem_rd, mem_wr, mem_addr_alu, ir_wr, reg_wr;
    logic reg_from_mem, reg_dst_rd, target_wr, pc_wr, pc_wr_cond;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    mcode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .uaddr(uaddr), .alu_op(alu_op),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr_alu(mem_addr_alu), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .reg_from_mem(reg_from_mem), .reg_dst_rd(reg_dst_rd), .target_wr(target_wr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src)
    );

    always #5 clk = ~clk;

    // Expected controls per step: {alu2,a,b3,rd,wr,aa,ir,rw,fm,drd,tw,pw,pwc,ps2}
    function automatic logic [17:0] exp_ctl(int s);
        case (s)
            0:  return {2'b00, 1'b0, 3'b001, 10'b1001000010, 2'b00};
            1:  return {2'b00, 1'b0, 3'b011, 10'b0000000100, 2'b00};
            2:  return {2'b00, 1'b1, 3'b010, 10'b0000000000, 2'b00};
            3:  return {2'b00, 1'b0, 3'b000, 10'b1010000000, 2'b00};
            4:  return {2'b00, 1'b0, 3'b000, 10'b0000110000, 2'b00};
            5:  return {2'b00, 1'b1, 3'b010, 10'b0000000000, 2'b00};
            6:  return {2'b00, 1'b0, 3'b000, 10'b0110000000, 2'b00};
            7:  return {2'b10, 1'b1, 3'b000, 10'b0000000000, 2'b00};
            8:  return {2'b00, 1'b0, 3'b000, 10'b0000101000, 2'b00};
            9:  return {2'b11, 1'b1, 3'b100, 10'b0000000000, 2'b00};
            10: return {2'b00, 1'b0, 3'b000, 10'b0000100000, 2'b00};
            11: return {2'b01, 1'b1, 3'b000, 10'b0000000001, 2'b01};
            12: return {2'b00, 1'b0, 3'b000, 10'b0000000010, 2'b10};
            default: return 18'd0;
        endcase
    endfunction

    function automatic string ctl_tag(int s);
        case (s)
            0: return "R1";
            1, 2, 5, 9: return "R7";
            3, 6: return "R9";
            4, 8, 10: return "R10";
            7: return "R6";
            11, 12: return "R8";
            default: return "R3";
        endcase
    endfunction

    function automatic int disp(logic [5:0] op);
        case (op)
            6'b000000: return 7;
            6'b100011: return 2;
            6'b101011: return 5;
            6'b001101: return 9;
            6'b000100: return 11;
            6'b000010: return 12;
            default:   return 0;
        endcase
    endfunction

    int    ref_upc = 0;
    string adr_tag = "R1";

    task automatic compare();
        logic [17:0] act;
        logic [17:0] exp;
        act = {alu_op, src_a_sel, src_b_sel, mem_rd, mem_wr, mem_addr_alu, ir_wr, reg_wr,
               reg_from_mem, reg_dst_rd, target_wr, pc_wr, pc_wr_cond, pc_src};
        exp = exp_ctl(ref_upc);
        checks++;
        if (uaddr !== 4'(ref_upc)) begin
            failures++;
            $display("FAIL %s uaddr actual=%0d expected=%0d", adr_tag, uaddr, ref_upc);
        end
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s controls at step %0d actual=%b expected=%b",
                     ctl_tag(ref_upc), ref_upc, act, exp);
        end
    endtask

    // Predict the micro-address after the coming edge from the applied inputs.
    task automatic predict();
        if (!rst_n) begin
            adr_tag = (ref_upc == 1) ? "R11" : "R1";
            ref_upc = 0;
        end else if (ref_upc == 1) begin
            adr_tag = (disp(opcode) == 0) ? "R5" : "R4";
            ref_upc = disp(opcode);
        end else if (ref_upc inside {0, 2, 3, 5, 7, 9}) begin
            adr_tag = "R2";
            ref_upc = ref_upc + 1;
        end else begin
            adr_tag = "R3";
            ref_upc = 0;
        end
    endtask

    logic [5:0] ops [9] = '{6'b000000, 6'b100011, 6'b101011, 6'b001101, 6'b000100,
                            6'b000010, 6'b111111, 6'b000001, 6'b100011};

    initial begin
        int idx = 0;
        bit did_r11 = 1'b0;
        bit did_mid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ref_upc = 0;
        adr_tag = "R1";
        for (int c = 0; c < 200; c++) begin
            compare();
            rst_n = 1'b1;
            if (ref_upc == 0) begin
                opcode = ops[idx % 9];
                idx++;
            end
            // R11: reset lands together with a dispatch on a valid opcode.
            if (c >= 120 && !did_r11 && ref_upc == 1 && disp(opcode) != 0) begin
                rst_n = 1'b0;
                did_r11 = 1'b1;
            end
            // R1: reset in the middle of a load sequence.
            if (c >= 150 && !did_mid && ref_upc == 3) begin
                rst_n = 1'b0;
                did_mid = 1'b1;
            end
            predict();
            @(negedge clk);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule